// File: doc/BRIEF.md
# Byte-Lane Mask Sequencer

This block drives the four active-high byte-lane mask lines of a 32-bit sample memory. It lets the same memory store one 32-bit channel, two 16-bit channels or four 8-bit channels of samples. A free-running address generator sweeps the memory over and over, and it raises a one-cycle wrap pulse at the end of each pass. The sequencer holds a four-bit mask pattern. A start strobe loads that pattern with a value chosen by the capture mode. Each wrap pulse then rotates the pattern, so that successive passes write successive lanes.

When the last pass of a capture has finished, the block raises a done flag and sets every mask bit, so the memory accepts no more writes. A lane index output gives the lowest lane that is open for writing, which the data path can use to tag samples. The memory controller, the address generator and the sample path lie outside this block.

Top module: `lane_mask_seq`

## Requirements
- R1: While `rst` is high, the block sets `mask` to 4'b1111 at each clock edge, clears `done` and returns to idle, and `lane_idx` reads 0. Reset is synchronous and active high.
- R2: Bit i of `mask` belongs to byte lane i, where lane 0 is data bits 7:0. A 1 blocks writes to that lane and a 0 allows them. A start with `mode` = 2'b00 loads 4'b0000, and `mask` holds that value until the capture ends.
- R3: A start with `mode` = 2'b01 loads 4'b1010. The first wrap turns it into 4'b0101.
- R4: A start with `mode` = 2'b10 loads 4'b1110. Each wrap rotates the mask left by one bit, with bit 3 moving into bit 0, giving 1101, then 1011, then 0111.
- R5: The wrap that completes the capture sets `done` and sets `mask` to 4'b1111 on the next edge. That is the 1st wrap for mode 00 or 11, the 2nd for mode 01 and the 4th for mode 10, counted from the start.
- R6: A wrap pulse changes nothing while `done` is high, and nothing in the idle state after reset before any start.
- R7: A start in the same cycle as a wrap loads the preset and ignores the wrap. A start during a capture, or after `done`, restarts the capture: it clears `done` and restarts the wrap count.
- R8: `lane_idx` gives the bit position of the lowest 0 in `mask`. It reads 0 when `mask` is all ones.
- R9: `mode` is sampled only on a start. Changing it during a capture does not change the mask pattern or the length of the capture.
- R10: The reserved `mode` value 2'b11 behaves exactly like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Capture mode: 00 = 32-bit, 01 = 16-bit, 10 = 8-bit, 11 = 32-bit |
| start | input | 1 | Loads the preset for `mode` and begins a capture |
| wrap | input | 1 | One-cycle pulse at the end of each address sweep |
| mask | output | 4 | Active-high byte-lane write masks |
| lane_idx | output | 2 | Position of the lowest zero bit of `mask` |
| done | output | 1 | All passes of the capture are complete |

## Verification
A wrong preset or a wrong rotation shows on `mask` and `lane_idx` one edge after the start or the wrap that caused it. A wrong sweep count stays hidden until the final wrap of a capture. It then shows as `done` rising one pass early or late, or not at all, so each mode is run through to its end, and wraps are sent after `done`. A start that arrives in the middle of a capture checks that the count restarts. If it did not, `done` would rise on the wrong pass.

// File: rtl/lane_mask_seq.sv
module lane_mask_seq #(
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(LANES),
  parameter int CNT_W = $clog2(LANES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic             wrap,
  output logic [LANES-1:0] mask,
  output logic [IDX_W-1:0] lane_idx,
  output logic             done
);

  localparam logic [LANES-1:0] ALL_ON = '1;

  function automatic logic [LANES-1:0] half_pat();
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = (i % 2 == 1);
    return p;
  endfunction

  logic             armed;
  logic [CNT_W-1:0] swept, target;
  logic [LANES-1:0] preset_val;
  logic [CNT_W-1:0] preset_tgt;

  always_comb begin
    unique case (mode)
      2'b01:   begin preset_val = half_pat();        preset_tgt = CNT_W'(2); end
      2'b10:   begin preset_val = ALL_ON << 1;       preset_tgt = CNT_W'(LANES); end
      default: begin preset_val = '0;                preset_tgt = CNT_W'(1); end
    endcase
  end

  wire              take_wrap = armed && wrap && !start;
  wire [CNT_W-1:0]  swept_nx  = swept + 1'b1;
  wire [LANES-1:0]  rot       = {mask[LANES-2:0], mask[LANES-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= ALL_ON;
      done   <= 1'b0;
      armed  <= 1'b0;
      swept  <= '0;
      target <= CNT_W'(1);
    end else if (start) begin
      mask   <= preset_val;
      target <= preset_tgt;
      done   <= 1'b0;
      armed  <= 1'b1;
      swept  <= '0;
    end else if (take_wrap) begin
      swept <= swept_nx;
      if (swept_nx == target) begin
        done  <= 1'b1;
        armed <= 1'b0;
        mask  <= ALL_ON;
      end else begin
        mask <= rot;
      end
    end
  end

  always_comb begin
    lane_idx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (!mask[i]) lane_idx = IDX_W'(i);
  end

  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    done |-> mask == ALL_ON) else $error("done with open lanes"); // R5

  AST_LATE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (done && wrap && !start) |=> (done && mask == ALL_ON)) else $error("wrap after done acted"); // R6

  AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && mask != ALL_ON)) else $error("start did not load"); // R7

  AST_OPEN_COUNT: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($countones(~mask) == 1 || $countones(~mask) == 2 || $countones(~mask) == LANES))
    else $error("bad open-lane count"); // R2

  AST_IDX_OPEN: assert property (@(posedge clk) disable iff (rst)
    (mask != ALL_ON) |-> !mask[lane_idx]) else $error("index on blocked lane"); // R8

  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && wrap && !start) |=> (done || mask == {$past(mask[LANES-2:0]), $past(mask[LANES-1])}))
    else $error("bad rotation"); // R4

endmodule

// File: tb/lane_mask_seq_bench.sv
module lane_mask_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       start = 1'b0;
  logic       wrap = 1'b0;
  logic [3:0] mask;
  logic [1:0] lane_idx;
  logic       done;

  always #10 clk = ~clk;

  lane_mask_seq u_lane_mask_seq (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .wrap(wrap),
    .mask(mask), .lane_idx(lane_idx), .done(done)
  );

  typedef struct {
    logic [3:0] mask;
    logic [1:0] idx;
    logic       done;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0] m_mask = 4'hF;
  logic       m_done = 0, m_armed = 0;
  int         m_cnt = 0, m_tgt = 1;

  function automatic logic [1:0] low_zero(logic [3:0] m);
    for (int i = 0; i < 4; i++) if (!m[i]) return 2'(i);
    return 2'd0;
  endfunction

  task automatic step(input logic r, input logic [1:0] md, input logic s,
                      input logic w, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; mode = md; start = s; wrap = w;
    if (r) begin
      m_mask = 4'hF; m_done = 0; m_armed = 0; m_cnt = 0;
    end else if (s) begin
      m_done = 0; m_armed = 1; m_cnt = 0;
      case (md)
        2'b01: begin m_mask = 4'b1010; m_tgt = 2; end
        2'b10: begin m_mask = 4'b1110; m_tgt = 4; end
        default: begin m_mask = 4'b0000; m_tgt = 1; end
      endcase
    end else if (w && m_armed) begin
      m_cnt++;
      if (m_cnt == m_tgt) begin
        m_done = 1; m_armed = 0; m_mask = 4'hF;
      end else m_mask = {m_mask[2:0], m_mask[3]};
    end
    e.mask = m_mask; e.idx = low_zero(m_mask); e.done = m_done; e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (mask !== e.mask || lane_idx !== e.idx || done !== e.done) begin
        bad++;
        $display("FAIL %s: got mask=%b idx=%0d done=%b exp mask=%b idx=%0d done=%b",
                 e.tag, mask, lane_idx, done, e.mask, e.idx, e.done);
      end
    end
  end

  initial begin
    step(1, 2'b00, 0, 0, "R1 reset");
    step(1, 2'b00, 0, 0, "R1 reset hold");
    step(0, 2'b00, 0, 0, "R1 idle");
    step(0, 2'b00, 0, 1, "R6 wrap while idle");
    // 32-bit
    step(0, 2'b00, 1, 0, "R2 preset 32");
    step(0, 2'b00, 0, 0, "R2 hold 32");
    step(0, 2'b00, 0, 1, "R5 done 32");
    step(0, 2'b00, 0, 1, "R6 wrap after done");
    // reserved
    step(0, 2'b11, 1, 0, "R10 reserved preset");
    step(0, 2'b11, 0, 1, "R10 reserved done");
    // 16-bit
    step(0, 2'b01, 1, 0, "R3 preset 16");
    step(0, 2'b10, 0, 0, "R9 mode change ignored");
    step(0, 2'b10, 0, 1, "R3 R8 rotate 16");
    step(0, 2'b00, 0, 1, "R5 R9 done 16");
    // 8-bit
    step(0, 2'b10, 1, 0, "R4 preset 8");
    step(0, 2'b10, 0, 1, "R4 R8 lane 1");
    step(0, 2'b10, 0, 0, "R4 hold");
    step(0, 2'b10, 0, 1, "R4 R8 lane 2");
    step(0, 2'b10, 0, 1, "R4 R8 lane 3");
    step(0, 2'b10, 0, 1, "R5 done 8");
    step(0, 2'b10, 0, 1, "R6 wrap after done 8");
    // priority and restart
    step(0, 2'b10, 1, 1, "R7 start beats wrap");
    step(0, 2'b10, 0, 1, "R7 first wrap");
    step(0, 2'b01, 1, 0, "R7 restart mid capture");
    step(0, 2'b01, 0, 1, "R7 count restarted");
    step(0, 2'b01, 0, 1, "R7 done after restart");
    step(0, 2'b00, 1, 0, "R7 start after done");
    step(1, 2'b00, 0, 0, "R1 reset mid capture");
    step(0, 2'b00, 0, 1, "R6 wrap after reset");
    step(0, 2'b00, 0, 0, "R1 idle end");
    @(posedge clk); #8;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule